// File: doc/BRIEF.md
# Two-Dimensional Strided Address Generator

This block walks a rectangular pattern of memory addresses and offers one address per handshake to a memory port. Its settings are a start address, a count of elements per row, a signed byte step between elements, a count of rows and a signed byte step applied at the end of each row. It also takes a 2D-enable bit, an autobuffer bit and a direction bit. When the element and row steps are equal, the pattern is a contiguous stream, such as a whole framebuffer sent to a display. When the row step is larger, the block writes a sub-rectangle into a wider image. A small logo placed in a 480-pixel-wide, 3-byte-per-pixel buffer with 16-bit elements uses an element step of 2 and a row step of (480 − width) × 3 + 2.

The generator starts when the enable input is high while it is idle. It reports a run flag for the whole time it is walking. It raises a sticky done flag after the last element of a finite pattern. It raises a sticky error flag if it is started with an empty pattern. Each flag has its own clear pulse, which acts as a write-one-to-clear. In autobuffer mode the pattern restarts from the start address and never completes. Dropping enable stops the walk at once.

The controller has four states. S_IDLE waits for enable. From there, T_START goes to S_RUN and T_REJECT goes to S_FAULT. S_RUN issues requests. Inside it, T_WRAP is the autobuffer reload. It leaves by T_COMPLETE to S_FINISH or by T_ABORT to S_IDLE. S_FINISH and S_FAULT hold until enable falls, and T_RELEASE takes them back to S_IDLE.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset the block is in S_IDLE: req_valid, busy, done and err are all 0.
- R2: When cfg_en is high in S_IDLE with a non-empty pattern, busy and req_valid are high from the next cycle on, and the first req_addr equals cfg_start_addr.
- R3: Inside a row, each accepted request (req_valid and req_ready both high) advances req_addr by cfg_x_mod, read as a signed 16-bit value.
- R4: An accepted request that is the last element of a row, but not of the last row, advances req_addr by cfg_y_mod (signed 16-bit) instead. The element count then restarts at cfg_x_count.
- R5: With cfg_two_d = 0 the pattern is a single row of cfg_x_count elements. cfg_y_count and cfg_y_mod have no effect, and a cfg_y_count of 0 is accepted.
- R6: While req_valid is high and req_ready is low, req_addr and req_last hold their values.
- R7: req_last is high exactly on the final element of the pattern. When that element is accepted without autobuffer, done is set in the next cycle and busy falls to 0.
- R8: With cfg_auto = 1, the request after the final element returns to cfg_start_addr and the walk goes on. done stays 0.
- R9: When cfg_en goes low during a walk, req_valid falls at once, busy is 0 from the next cycle on, and done is not set.
- R10: Starting with cfg_x_count = 0, or with cfg_two_d = 1 and cfg_y_count = 0, sets err in the next cycle. No request is issued and busy stays 0.
- R11: A one-cycle pulse on clr_done or clr_err clears that flag in the next cycle.
- R12: req_write gives the value that cfg_write had at the start of the walk. Later changes to cfg_write do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start_addr | input | 32 | First byte address of the pattern |
| cfg_x_count | input | 16 | Elements per row |
| cfg_x_mod | input | 16 | Signed byte step between elements |
| cfg_y_count | input | 16 | Rows per pattern (used when cfg_two_d is 1) |
| cfg_y_mod | input | 16 | Signed byte step after the last element of a row |
| cfg_two_d | input | 1 | 1: rectangular pattern; 0: single row |
| cfg_auto | input | 1 | 1: restart the pattern after its final element |
| cfg_write | input | 1 | Direction, latched at start |
| cfg_en | input | 1 | Run enable; low stops the walk |
| clr_done | input | 1 | Pulse that clears done |
| clr_err | input | 1 | Pulse that clears err |
| req_ready | input | 1 | Memory port accepts the current request |
| req_valid | output | 1 | A request is offered |
| req_addr | output | 32 | Byte address of the current request |
| req_last | output | 1 | Current request is the final element of the pattern |
| req_write | output | 1 | Latched direction of the current walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Sticky: a finite pattern completed |
| err | output | 1 | Sticky: a start was rejected as empty |

## Verification
Two situations are hard to reach from the ports. The first is the row-end step landing on a stalled request. The second is a backward walk that needs negative steps. The stimulus table therefore includes a sub-rectangle vector whose row step differs from its element step. The stall vectors drop req_ready on every odd element, so a row boundary arrives while the port is stalling. The autobuffer wrap is reached by running a small pattern past its final element and checking that the fifth request returns to the start address. An abort is brought about by dropping enable in the middle of a row.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int MOD_W  = 16;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RUN    = 2'd1,
        S_FINISH = 2'd2,
        S_FAULT  = 2'd3
    } walk_state_t;
endpackage

// File: rtl/dma2d_walk.sv
module dma2d_walk #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int MW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] start,
    input  logic [CW-1:0] x_count,
    input  logic [MW-1:0] x_mod,
    input  logic [CW-1:0] y_count,
    input  logic [MW-1:0] y_mod,
    input  logic          two_d,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    localparam int EXT_W = AW - MW;
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [AW-1:0] start_q;
    logic [CW-1:0] xc_q, yc_q, x_left, y_left;
    logic [AW-1:0] xstep, ystep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            xc_q    <= '0;
            yc_q    <= '0;
            xstep   <= '0;
            ystep   <= '0;
            addr    <= '0;
            x_left  <= '0;
            y_left  <= '0;
        end else if (load) begin
            start_q <= start;
            xc_q    <= x_count;
            yc_q    <= two_d ? y_count : ONE;
            xstep   <= {{EXT_W{x_mod[MW-1]}}, x_mod};
            ystep   <= {{EXT_W{y_mod[MW-1]}}, y_mod};
            addr    <= start;
            x_left  <= x_count;
            y_left  <= two_d ? y_count : ONE;
        end else if (step) begin
            if (x_left != ONE) begin
                addr   <= addr + xstep;
                x_left <= x_left - ONE;
            end else if (y_left != ONE) begin
                addr   <= addr + ystep;
                x_left <= xc_q;
                y_left <= y_left - ONE;
            end else begin
                addr   <= start_q;
                x_left <= xc_q;
                y_left <= yc_q;
            end
        end
    end

    assign at_end = (x_left == ONE) && (y_left == ONE);
endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
    import dma2d_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_en,
    input  logic        cfg_auto,
    input  logic        cfg_bad,
    input  logic        req_ready,
    input  logic        at_end,
    output logic        load,
    output logic        step,
    output logic        req_valid,
    output logic        busy,
    output logic        set_done,
    output logic        set_err
);
    walk_state_t state, state_nx;
    logic        auto_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            auto_q <= 1'b0;
        end else begin
            state  <= state_nx;
            if (load) auto_q <= cfg_auto;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (cfg_en) state_nx = cfg_bad ? S_FAULT : S_RUN;
            S_RUN: begin
                if (!cfg_en)                          state_nx = S_IDLE;
                else if (req_ready && at_end && !auto_q) state_nx = S_FINISH;
            end
            S_FINISH: if (!cfg_en) state_nx = S_IDLE;
            S_FAULT:  if (!cfg_en) state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        load      = (state == S_IDLE) && cfg_en && !cfg_bad;
        set_err   = (state == S_IDLE) && cfg_en && cfg_bad;
        busy      = (state == S_RUN);
        req_valid = busy && cfg_en;
        step      = req_valid && req_ready;
        set_done  = step && at_end && !auto_q;
    end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W,
    parameter int MW = MOD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_start_addr,
    input  logic [CW-1:0] cfg_x_count,
    input  logic [MW-1:0] cfg_x_mod,
    input  logic [CW-1:0] cfg_y_count,
    input  logic [MW-1:0] cfg_y_mod,
    input  logic          cfg_two_d,
    input  logic          cfg_auto,
    input  logic          cfg_write,
    input  logic          cfg_en,
    input  logic          clr_done,
    input  logic          clr_err,
    input  logic          req_ready,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic          req_last,
    output logic          req_write,
    output logic          busy,
    output logic          done,
    output logic          err
);
    logic load, step, set_done, set_err, at_end, cfg_bad;

    assign cfg_bad = (cfg_x_count == '0) || (cfg_two_d && (cfg_y_count == '0));

    dma2d_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_auto  (cfg_auto),
        .cfg_bad   (cfg_bad),
        .req_ready (req_ready),
        .at_end    (at_end),
        .load      (load),
        .step      (step),
        .req_valid (req_valid),
        .busy      (busy),
        .set_done  (set_done),
        .set_err   (set_err)
    );

    dma2d_walk #(.AW(AW), .CW(CW), .MW(MW)) i_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .start   (cfg_start_addr),
        .x_count (cfg_x_count),
        .x_mod   (cfg_x_mod),
        .y_count (cfg_y_count),
        .y_mod   (cfg_y_mod),
        .two_d   (cfg_two_d),
        .addr    (req_addr),
        .at_end  (at_end)
    );

    assign req_last = at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            err       <= 1'b0;
            req_write <= 1'b0;
        end else begin
            if (set_done)      done <= 1'b1;
            else if (clr_done) done <= 1'b0;
            if (set_err)       err  <= 1'b1;
            else if (clr_err)  err  <= 1'b0;
            if (load)          req_write <= cfg_write;
        end
    end
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_en,
    input logic          req_ready,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          req_last,
    input logic          busy,
    input logic          done,
    input logic          err
);
    a_r2_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (!req_valid || ($stable(req_addr) && $stable(req_last))));

    a_r7_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);

    a_r9_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !busy);

    a_r10_err_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!req_valid && !busy));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_last  (req_last),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [31:0] start;
        logic [15:0] xc;
        logic [15:0] xm;
        logic [15:0] yc;
        logic [15:0] ym;
        logic        two_d;
        logic        stall;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 16'd4, 16'd4,      16'd3, 16'd4,      1'b1, 1'b0},
        '{32'h2000_1C32, 16'd6, 16'd2,      16'd3, 16'h0596,   1'b1, 1'b1},
        '{32'h0000_8000, 16'd3, 16'hFFFC,   16'd2, 16'hFF00,   1'b1, 1'b0},
        '{32'h0000_0040, 16'd3, 16'd8,      16'd0, 16'h7FFF,   1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_start_addr = '0;
    logic [15:0] cfg_x_count = '0, cfg_x_mod = '0, cfg_y_count = '0, cfg_y_mod = '0;
    logic        cfg_two_d = 1'b0, cfg_auto = 1'b0, cfg_write = 1'b0, cfg_en = 1'b0;
    logic        clr_done = 1'b0, clr_err = 1'b0, req_ready = 1'b0;
    logic        req_valid, req_last, req_write, busy, done, err;
    logic [31:0] req_addr;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma2d_addr_gen i_dma2d_addr_gen (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic setup(input vec_t v, input logic au);
        cfg_start_addr = v.start;
        cfg_x_count    = v.xc;
        cfg_x_mod      = v.xm;
        cfg_y_count    = v.yc;
        cfg_y_mod      = v.ym;
        cfg_two_d      = v.two_d;
        cfg_auto       = au;
    endtask

    // Walks one full finite pattern and checks every request (R2..R7)
    task automatic run_vec(input vec_t v);
        logic [31:0] a;
        int rows;
        a = v.start;
        rows = v.two_d ? int'(v.yc) : 1;
        setup(v, 1'b0);
        cfg_en = 1'b1;
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < int'(v.xc); c++) begin
                @(negedge clk);
                if (v.stall && (c % 2 == 1)) begin
                    req_ready = 1'b0;
                    @(negedge clk);
                    chk("R6 stall addr", req_addr, a);
                    req_ready = 1'b1;
                end
                chk("R2 valid", {31'd0, req_valid}, 32'd1);
                chk((c == 0) ? "R4 row addr" : "R3 elem addr", req_addr, a);
                chk("R7 last flag", {31'd0, req_last},
                    {31'd0, (r == rows-1) && (c == int'(v.xc)-1)});
                if (c < int'(v.xc)-1) a = a + {{16{v.xm[15]}}, v.xm};
                else                  a = a + {{16{v.ym[15]}}, v.ym};
            end
        end
        @(negedge clk);
        chk("R7 done set", {31'd0, done}, 32'd1);
        chk("R7 busy low", {31'd0, busy}, 32'd0);
        cfg_en = 1'b0;
        clr_done = 1'b1;
        @(negedge clk);
        clr_done = 1'b0;
        chk("R11 done cleared", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        vec_t v;
        req_ready = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'd0, req_valid}, 32'd0);
        chk("R1 busy",  {31'd0, busy}, 32'd0);
        chk("R1 done",  {31'd0, done}, 32'd0);
        chk("R1 err",   {31'd0, err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R6 R7 table of patterns
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R8 autobuffer wrap
        v = '{32'h0000_0100, 16'd2, 16'd4, 16'd2, 16'h0010, 1'b1, 1'b0};
        setup(v, 1'b1);
        cfg_en = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 wrap addr", req_addr, 32'h0000_0100);
        chk("R8 still busy", {31'd0, busy}, 32'd1);
        chk("R8 no done", {31'd0, done}, 32'd0);

        // R9 disable mid-walk
        cfg_en = 1'b0;
        #1;
        chk("R9 valid drops", {31'd0, req_valid}, 32'd0);
        @(negedge clk);
        chk("R9 busy low", {31'd0, busy}, 32'd0);
        chk("R9 no done", {31'd0, done}, 32'd0);

        // R12 direction latched at start
        setup(VECS[0], 1'b0);
        cfg_write = 1'b1;
        cfg_en = 1'b1;
        @(negedge clk);
        cfg_write = 1'b0;
        @(negedge clk);
        chk("R12 write latched", {31'd0, req_write}, 32'd1);
        cfg_en = 1'b0;
        @(negedge clk);

        // R10 zero x count
        v = '{32'h0, 16'd0, 16'd4, 16'd2, 16'd4, 1'b1, 1'b0};
        setup(v, 1'b0);
        cfg_en = 1'b1;
        @(negedge clk);
        chk("R10 err x zero", {31'd0, err}, 32'd1);
        chk("R10 no valid", {31'd0, req_valid}, 32'd0);
        chk("R10 no busy", {31'd0, busy}, 32'd0);
        cfg_en = 1'b0;
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
        chk("R11 err cleared", {31'd0, err}, 32'd0);

        // R10 zero y count in 2D mode
        v = '{32'h0, 16'd3, 16'd4, 16'd0, 16'd4, 1'b1, 1'b0};
        setup(v, 1'b0);
        cfg_en = 1'b1;
        @(negedge clk);
        chk("R10 err y zero", {31'd0, err}, 32'd1);
        cfg_en = 1'b0;
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;

        // R5 zero y count accepted in single-row mode
        v = '{32'h0, 16'd3, 16'd4, 16'd0, 16'd4, 1'b0, 1'b0};
        setup(v, 1'b0);
        cfg_en = 1'b1;
        @(negedge clk);
        chk("R5 no err 1D", {31'd0, err}, 32'd0);
        chk("R5 busy 1D", {31'd0, busy}, 32'd1);
        cfg_en = 1'b0;
        @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule